// File: doc/BRIEF.md
# Transmit DMA Channel Run-Control Register

This block holds the 32-bit real-time control and status word of one transmit DMA channel and the small state controller that acts on it. Software reads and writes the word through a simple write-enable/data port at any time, including while the channel is moving data. The controller turns the enable, pause, teardown and forced-teardown bits into three level outputs for a transfer engine: run, pause and flush. The engine reports back through four inputs: the end of a block transfer, an idle wait on a trigger, the end of a teardown, and an error event.

Disabling the channel is graceful. The channel keeps running until the current block finishes, or until the engine reports that it is only waiting on a trigger. Pausing takes effect at once. A teardown runs until the engine reports completion. Hardware then clears the enable bit, and software reads that as the completion signal. The teardown bit stays set. The forced-teardown modifier makes the engine abandon trigger waits and flush instead of transferring. An error event sets a sticky flag, and software clears the flag by writing 0 to it.

Top module: `dma_tx_rtctl`

## Requirements
- R1: Bit 31 is enable, bit 30 is teardown, bit 29 is pause, bit 28 is forced teardown and bit 0 is the error flag. Bits 27:1 always read 0, whatever is written to them. After reset the word reads 0 and run_o, pause_o and flush_o are 0.
- R2: A write loads bits 31:28 from the write data, and the new value reads back in the cycle after the write edge. Enabling an idle channel raises run_o one clock edge after the write edge.
- R3: When enable is cleared while the channel runs and teardown is 0, run_o stays 1 until an edge samples blk_done_i high. After that edge run_o is 0.
- R4: While pause reads 1, run_o is 0 and pause_o is 1. Clearing pause brings run_o back in the cycle where pause reads 0. No block boundary is needed in either direction.
- R5: During a teardown (teardown=1 with enable=1), run_o stays 1 until td_done_i. At the edge that samples td_done_i, hardware clears enable, so the word reads enable=0 and teardown=1 in the following cycle, and run_o is 0.
- R6: When forced teardown and teardown are both set and the channel is draining, flush_o is 1 and run_o is 0. Forced teardown without teardown leaves run_o at 1 and flush_o at 0. Forced teardown is still set after the teardown completes.
- R7: An error event sets bit 0. A write with bit 0 = 0 clears it. A write with bit 0 = 1 never sets it. An error event in the same cycle as a clearing write wins, so the flag stays 1.
- R8: A teardown in progress still completes, with enable cleared at td_done_i, even if software clears the teardown bit after the drain has begun.
- R9: While the channel is disabled, pulses on blk_done_i, trig_wait_i and td_done_i leave run_o and flush_o at 0 and do not change the word.
- R10: After a teardown, writing enable=1 together with teardown=1 keeps run_o at 0. Writing enable=1 with teardown=0 restarts the channel, and run_o is 1 one edge after the write edge.
- R11: A teardown requested while the channel is paused still completes on td_done_i, and run_o stays 0 throughout.
- R12: A disable drain also ends when trig_wait_i is sampled high, with no block boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| blk_done_i | input | 1 | Engine finished the current block transfer |
| trig_wait_i | input | 1 | Engine is idle, waiting on a trigger |
| td_done_i | input | 1 | Engine finished the teardown |
| err_evt_i | input | 1 | Channel error event |
| run_o | output | 1 | Engine may process the channel |
| pause_o | output | 1 | Channel is held by pause |
| flush_o | output | 1 | Engine must abandon waits and flush |

## Verification
The hardest situations to reach are the races on the control word. One is software clearing the teardown bit while a drain is already under way. Another is an error event arriving in the same cycle as a write that clears the flag. Directed sequences reach both. They walk the channel through run, pause, teardown while paused and forced teardown, then drive the race on exact negative edges. Seeded random writes then mix pause, forced-teardown, reserved and error-bit values with random engine pulses, both while the channel runs and while it is disabled. Each read-back is compared with a model of the bits kept in the bench.

// File: rtl/rtctl_pkg.sv
package rtctl_pkg;
  localparam int unsigned BIT_EN = 31;
  localparam int unsigned BIT_TD = 30;
  localparam int unsigned BIT_PA = 29;
  localparam int unsigned BIT_FT = 28;
  localparam int unsigned BIT_ER = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PAUSED,
    ST_DRAIN,
    ST_DOWN
  } chan_st_e;

  typedef struct packed {
    logic en;
    logic td;
    logic pa;
    logic ft;
    logic er;
  } ctl_bits_t;
endpackage

// File: rtl/rtctl_regs.sv
module rtctl_regs
  import rtctl_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_clr_en_i,
  input  logic             err_evt_i,
  output ctl_bits_t        bits_o,
  output logic [REG_W-1:0] rdata_o
);
  ctl_bits_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (hw_clr_en_i)   q.en <= 1'b0;
      else if (we_i)     q.en <= wdata_i[BIT_EN];
      if (we_i) begin
        q.td <= wdata_i[BIT_TD];
        q.pa <= wdata_i[BIT_PA];
        q.ft <= wdata_i[BIT_FT];
      end
      // event wins over a clearing write; software can only clear
      q.er <= err_evt_i | (q.er & ~(we_i & ~wdata_i[BIT_ER]));
    end
  end

  always_comb begin
    for (int i = 0; i < REG_W; i++) rdata_o[i] = 1'b0;
    rdata_o[BIT_EN] = q.en;
    rdata_o[BIT_TD] = q.td;
    rdata_o[BIT_PA] = q.pa;
    rdata_o[BIT_FT] = q.ft;
    rdata_o[BIT_ER] = q.er;
  end

  assign bits_o = q;

  a_r5_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_en_i |=> !q.en);
  a_r5_td_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.td && !we_i) |=> q.td);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> q.er);
  a_r7_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[BIT_ER] && !q.er && !err_evt_i) |=> !q.er);
endmodule

// File: rtl/rtctl_fsm.sv
module rtctl_fsm
  import rtctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ctl_bits_t bits_i,
  input  logic      blk_done_i,
  input  logic      trig_wait_i,
  input  logic      td_done_i,
  output logic      run_o,
  output logic      pause_o,
  output logic      flush_o,
  output logic      hw_clr_en_o
);
  chan_st_e st_q, st_d;
  logic     drain_td_q;
  logic     active;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (bits_i.en) st_d = bits_i.td ? ST_DRAIN : (bits_i.pa ? ST_PAUSED : ST_RUN);
      ST_RUN:    if (bits_i.td || !bits_i.en) st_d = ST_DRAIN;
                 else if (bits_i.pa)          st_d = ST_PAUSED;
      ST_PAUSED: if (bits_i.td)               st_d = ST_DRAIN;
                 else if (!bits_i.en)         st_d = ST_IDLE;
                 else if (!bits_i.pa)         st_d = ST_RUN;
      ST_DRAIN:  if (drain_td_q) begin
                   if (td_done_i) st_d = ST_DOWN;
                 end else if (blk_done_i || trig_wait_i) begin
                   st_d = ST_IDLE;
                 end
      ST_DOWN:   if (bits_i.en && !bits_i.td)        st_d = bits_i.pa ? ST_PAUSED : ST_RUN;
                 else if (!bits_i.en && !bits_i.td)  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      drain_td_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // latch drain kind on entry; a later teardown request upgrades it
      if (st_q != ST_DRAIN)  drain_td_q <= bits_i.td;
      else                   drain_td_q <= drain_td_q | bits_i.td;
    end
  end

  assign active      = (st_q == ST_RUN) || (st_q == ST_PAUSED) || (st_q == ST_DRAIN);
  assign flush_o     = (st_q == ST_DRAIN) && drain_td_q && bits_i.ft;
  assign run_o       = active && !bits_i.pa && !flush_o;
  assign pause_o     = active && bits_i.pa;
  assign hw_clr_en_o = (st_q == ST_DRAIN) && drain_td_q && td_done_i;

  a_r4_pause_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_i.pa |-> !run_o);
  a_r6_flush_needs_ft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (bits_i.ft && !run_o));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (!run_o && !flush_o && !hw_clr_en_o));
  a_r3_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && !drain_td_q && !bits_i.td && !blk_done_i && !trig_wait_i)
      |=> (st_q == ST_DRAIN));
  a_r8_td_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && drain_td_q && !td_done_i) |=> (st_q == ST_DRAIN));
endmodule

// File: rtl/dma_tx_rtctl.sv
module dma_tx_rtctl
  import rtctl_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             blk_done_i,
  input  logic             trig_wait_i,
  input  logic             td_done_i,
  input  logic             err_evt_i,
  output logic             run_o,
  output logic             pause_o,
  output logic             flush_o
);
  ctl_bits_t bits;
  logic      hw_clr_en;

  rtctl_regs #(.REG_W(REG_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .hw_clr_en_i (hw_clr_en),
    .err_evt_i   (err_evt_i),
    .bits_o      (bits),
    .rdata_o     (reg_rdata_o)
  );

  rtctl_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bits_i      (bits),
    .blk_done_i  (blk_done_i),
    .trig_wait_i (trig_wait_i),
    .td_done_i   (td_done_i),
    .run_o       (run_o),
    .pause_o     (pause_o),
    .flush_o     (flush_o),
    .hw_clr_en_o (hw_clr_en)
  );

  a_r2_run_needs_en_or_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !bits.en) |=> !run_o);
endmodule

// File: tb/test_dma_tx_rtctl.sv
module test_dma_tx_rtctl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        blk_done_i = 1'b0, trig_wait_i = 1'b0, td_done_i = 1'b0, err_evt_i = 1'b0;
  logic        run_o, pause_o, flush_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_tx_rtctl i_dma_tx_rtctl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .blk_done_i, .trig_wait_i, .td_done_i, .err_evt_i,
    .run_o, .pause_o, .flush_o
  );

  function automatic logic [31:0] exp_word(bit en, bit td, bit pa, bit ft, bit er);
    return {en, td, pa, ft, 27'd0, er};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [31:0] exp);
    chk(reg_rdata_o === exp, tag, reg_rdata_o, exp);
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    chk(act === exp, tag, {31'd0, act}, {31'd0, exp});
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_td_done();
    @(negedge clk_i); td_done_i = 1'b1;
    @(negedge clk_i); td_done_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit m_pa, m_ft, m_er, we, ev;
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk_word("R1 reset word", 32'h0);
    chk_bit("R1 reset run", run_o, 1'b0);
    chk_bit("R1 reset pause", pause_o, 1'b0);
    chk_bit("R1 reset flush", flush_o, 1'b0);

    // R9 idle ignores engine inputs
    @(negedge clk_i); blk_done_i = 1; trig_wait_i = 1; td_done_i = 1;
    step(3);
    chk_bit("R9 idle run", run_o, 1'b0);
    chk_bit("R9 idle flush", flush_o, 1'b0);
    chk_word("R9 idle word", 32'h0);
    blk_done_i = 0; trig_wait_i = 0; td_done_i = 0;

    // R2 enable
    wr(32'h8000_0000);
    chk_word("R2 readback", 32'h8000_0000);
    chk_bit("R2 not yet running", run_o, 1'b0);
    step(1);
    chk_bit("R2 running", run_o, 1'b1);

    // R4 pause immediate
    wr(32'hA000_0000);
    chk_bit("R4 paused run", run_o, 1'b0);
    chk_bit("R4 pause_o", pause_o, 1'b1);
    wr(32'h8000_0000);
    chk_bit("R4 resume run", run_o, 1'b1);
    chk_bit("R4 resume pause_o", pause_o, 1'b0);

    // R3 disable waits for block boundary
    wr(32'h0);
    step(3);
    chk_bit("R3 draining run", run_o, 1'b1);
    @(negedge clk_i); blk_done_i = 1;
    @(negedge clk_i); blk_done_i = 0;
    chk_bit("R3 halted", run_o, 1'b0);

    // R12 trigger wait ends disable drain
    wr(32'h8000_0000); step(1);
    chk_bit("R12 running", run_o, 1'b1);
    wr(32'h0); step(2);
    chk_bit("R12 draining", run_o, 1'b1);
    @(negedge clk_i); trig_wait_i = 1;
    @(negedge clk_i); trig_wait_i = 0;
    chk_bit("R12 halted", run_o, 1'b0);

    // R5 teardown
    wr(32'h8000_0000); step(1);
    wr(32'hC000_0000); step(1);
    chk_bit("R5 run during teardown", run_o, 1'b1);
    chk_word("R5 before done", 32'hC000_0000);
    pulse_td_done();
    chk_word("R5 enable cleared", 32'h4000_0000);
    chk_bit("R5 run after done", run_o, 1'b0);

    // R10 restart rules
    wr(32'hC000_0000); step(2);
    chk_bit("R10 en+td stays down", run_o, 1'b0);
    wr(32'h8000_0000); step(1);
    chk_bit("R10 restart", run_o, 1'b1);

    // R6 forced teardown
    wr(32'h9000_0000); step(2);
    chk_bit("R6 ft alone run", run_o, 1'b1);
    chk_bit("R6 ft alone flush", flush_o, 1'b0);
    wr(32'hD000_0000); step(1);
    chk_bit("R6 flush", flush_o, 1'b1);
    chk_bit("R6 run off", run_o, 1'b0);
    pulse_td_done();
    chk_word("R6 bits kept", 32'h5000_0000);
    chk_bit("R6 flush off", flush_o, 1'b0);

    // R11 teardown while paused
    wr(32'h8000_0000); step(1);
    wr(32'hA000_0000); step(1);
    wr(32'hE000_0000);
    chk_bit("R11 run off", run_o, 1'b0);
    step(2);
    chk_bit("R11 run still off", run_o, 1'b0);
    pulse_td_done();
    chk_word("R11 completed", 32'h6000_0000);

    // R8 teardown bit withdrawn mid-drain
    wr(32'h8000_0000); step(1);
    wr(32'hC000_0000); step(1);
    wr(32'h8000_0000); step(2);
    chk_bit("R8 still draining", run_o, 1'b1);
    pulse_td_done();
    chk_word("R8 completed", 32'h0);
    chk_bit("R8 run off", run_o, 1'b0);
    step(2);

    // R7 error flag
    @(negedge clk_i); err_evt_i = 1;
    @(negedge clk_i); err_evt_i = 0;
    chk_word("R7 set by event", 32'h1);
    wr(32'h1);
    chk_word("R7 write 1 keeps", 32'h1);
    wr(32'h0);
    chk_word("R7 write 0 clears", 32'h0);
    wr(32'h1);
    chk_word("R7 write 1 no set", 32'h0);
    @(negedge clk_i); err_evt_i = 1; reg_we_i = 1; reg_wdata_i = 32'h0;
    @(negedge clk_i); err_evt_i = 0; reg_we_i = 0;
    chk_word("R7 event beats clear", 32'h1);

    // random while running: R1 R4 R7 R8
    wr(32'h8000_0000); step(1);
    m_pa = 0; m_ft = 0; m_er = 0;
    for (int i = 0; i < 400; i++) begin
      we = ($urandom % 3) == 0;
      ev = ($urandom % 5) == 0;
      d = $urandom;
      d[31] = 1'b1; d[30] = 1'b0;
      @(negedge clk_i);
      reg_we_i = we; reg_wdata_i = d; err_evt_i = ev;
      blk_done_i = $urandom; trig_wait_i = $urandom; td_done_i = $urandom;
      if (we) begin m_pa = d[29]; m_ft = d[28]; end
      m_er = ev | (m_er & ~(we & ~d[0]));
      @(negedge clk_i);
      reg_we_i = 0; err_evt_i = 0;
      chk_word("R8 random run word", exp_word(1, 0, m_pa, m_ft, m_er));
      chk_bit("R4 random run", run_o, !m_pa);
      chk_bit("R6 random no flush", flush_o, 1'b0);
    end
    blk_done_i = 0; trig_wait_i = 0; td_done_i = 0;

    // random while disabled: R9 R7 R1
    wr(32'h0);
    @(negedge clk_i); blk_done_i = 1;
    @(negedge clk_i); blk_done_i = 0;
    m_pa = 0; m_ft = 0; m_er = 0;
    for (int i = 0; i < 400; i++) begin
      we = ($urandom % 3) == 0;
      ev = ($urandom % 6) == 0;
      d = $urandom;
      d[31] = 1'b0; d[30] = 1'b0;
      @(negedge clk_i);
      reg_we_i = we; reg_wdata_i = d; err_evt_i = ev;
      blk_done_i = $urandom; trig_wait_i = $urandom; td_done_i = $urandom;
      if (we) begin m_pa = d[29]; m_ft = d[28]; end
      m_er = ev | (m_er & ~(we & ~d[0]));
      @(negedge clk_i);
      reg_we_i = 0; err_evt_i = 0;
      chk_word("R9 random idle word", exp_word(0, 0, m_pa, m_ft, m_er));
      chk_bit("R9 random idle run", run_o, 1'b0);
      chk_bit("R9 random idle flush", flush_o, 1'b0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule